// File: doc/BRIEF.md
# DDR Controller and PHY Reset Sequencer

This block produces the ordered reset release for a DDR protocol controller and its PHY after power-on or a clock change. A single start pulse runs two stages back to back. In the first stage the block drives a four-bit soft-reset field. Bits 3:2 reset the controller and bits 1:0 reset the PHY. All four are set together. The PHY pair is cleared first, and the controller pair is cleared after a longer gap.

The second stage starts only after the first is complete. It drives two active-low resets inside the PHY. Both are held low for a short hold. The analog reset is then released, and the digital reset follows after a long gap. The long gap lets the analog side settle for at least 1000 DRAM clocks ahead of the digital side; 5 µs covers DRAM clocks down to 200 MHz.

Every delay is a parameter in reference-clock cycles. The short hold defaults to 1 µs and the long gap to 5 µs at 100 MHz. A busy output covers the whole run. A done output rises one cycle after the digital release and stays high until the next start.

Top module: `ddr_rst_seq`

## Requirements
- R1: After rst_ni is asserted, and while no start has been accepted, soft_rst_o is all ones, both PHY resets are low, and busy_o and done_o are low.
- R2: A start_i high at a clock edge while idle or done sets every soft_rst_o bit and drives phy_ana_rst_no and phy_dig_rst_no low from that edge.
- R3: The PHY bits soft_rst_o[1:0] clear SHORT_CYC cycles after the start edge. The controller bits soft_rst_o[3:2] clear a further LONG_CYC cycles later, and never before the PHY bits.
- R4: The PHY analog and digital resets stay low until soft_rst_o is entirely clear, and for SHORT_CYC further cycles after that.
- R5: phy_ana_rst_no rises 2*SHORT_CYC+LONG_CYC cycles after the start edge. phy_dig_rst_no rises LONG_CYC cycles after that, never ahead of the analog release.
- R6: busy_o is high from the start edge until done_o rises, and busy_o and done_o are never high together.
- R7: done_o rises exactly one cycle after phy_dig_rst_no rises and stays high, with all resets released, until the next accepted start.
- R8: start_i while busy_o is high has no effect on any output, at any point in the sequence.
- R9: start_i while done_o is high restarts the whole sequence from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a reset sequence |
| soft_rst_o | output | CTL_BITS+PHY_BITS | Soft reset, controller bits high, PHY bits low, active high |
| phy_ana_rst_no | output | 1 | PHY analog reset, active low |
| phy_dig_rst_no | output | 1 | PHY digital reset, active low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, resets released |

## Verification
The bench runs full sequences with short hold and gap values. It compares every output against a cycle-by-cycle timeline derived from the two delays, which separates an early or late release from a swapped order or a stage overlap. It then sweeps a second start pulse across every cycle of an active run; any reaction at any phase shows up as a timeline mismatch. Back-to-back runs restart from the done state, and a final idle stretch shows that done holds without a start.

// File: rtl/ddr_rst_pkg.sv
package ddr_rst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALL_RST,
    ST_PHY_FREE,
    ST_PHY_LOW,
    ST_ANA_FREE,
    ST_FIN,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/rst_gap_timer.sv
module rst_gap_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import ddr_rst_pkg::*;
#(
  parameter int SHORT_CYC = 100,
  parameter int LONG_CYC  = 500,
  parameter int CNT_W     = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             expire_i,
  output seq_state_e       state_o,
  output logic             clr_o,
  output logic [CNT_W-1:0] limit_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i)  state_d = ST_ALL_RST;
      ST_ALL_RST:       if (expire_i) state_d = ST_PHY_FREE;
      ST_PHY_FREE:      if (expire_i) state_d = ST_PHY_LOW;
      ST_PHY_LOW:       if (expire_i) state_d = ST_ANA_FREE;
      ST_ANA_FREE:      if (expire_i) state_d = ST_FIN;
      ST_FIN:                         state_d = ST_DONE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  // long gaps follow each release that must lead its partner
  always_comb begin
    if (state_q == ST_PHY_FREE || state_q == ST_ANA_FREE) limit_o = CNT_W'(LONG_CYC);
    else                                                  limit_o = CNT_W'(SHORT_CYC);
  end

  assign clr_o   = (state_d != state_q);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/rst_out_map.sv
module rst_out_map
  import ddr_rst_pkg::*;
#(
  parameter int CTL_BITS = 2,
  parameter int PHY_BITS = 2
) (
  input  seq_state_e                   state_i,
  output logic [CTL_BITS+PHY_BITS-1:0] soft_rst_o,
  output logic                         ana_rst_no,
  output logic                         dig_rst_no,
  output logic                         busy_o,
  output logic                         done_o
);
  logic ctl_on, phy_on;

  assign ctl_on = (state_i == ST_IDLE) || (state_i == ST_ALL_RST) || (state_i == ST_PHY_FREE);
  assign phy_on = (state_i == ST_IDLE) || (state_i == ST_ALL_RST);

  for (genvar g = 0; g < PHY_BITS; g++) begin : g_phy
    assign soft_rst_o[g] = phy_on;
  end
  for (genvar g = 0; g < CTL_BITS; g++) begin : g_ctl
    assign soft_rst_o[PHY_BITS+g] = ctl_on;
  end

  assign ana_rst_no = (state_i == ST_ANA_FREE) || (state_i == ST_FIN) || (state_i == ST_DONE);
  assign dig_rst_no = (state_i == ST_FIN) || (state_i == ST_DONE);
  assign busy_o     = (state_i != ST_IDLE) && (state_i != ST_DONE);
  assign done_o     = (state_i == ST_DONE);
endmodule

// File: rtl/ddr_rst_seq.sv
module ddr_rst_seq
  import ddr_rst_pkg::*;
#(
  parameter int SHORT_CYC = 100,
  parameter int LONG_CYC  = 500,
  parameter int CTL_BITS  = 2,
  parameter int PHY_BITS  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  output logic [CTL_BITS+PHY_BITS-1:0] soft_rst_o,
  output logic                         phy_ana_rst_no,
  output logic                         phy_dig_rst_no,
  output logic                         busy_o,
  output logic                         done_o
);
  localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e       state;
  logic             clr, expire;
  logic [CNT_W-1:0] limit;

  rst_seq_fsm #(
    .SHORT_CYC(SHORT_CYC),
    .LONG_CYC (LONG_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .expire_i(expire),
    .state_o (state),
    .clr_o   (clr),
    .limit_o (limit)
  );

  rst_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .limit_i (limit),
    .expire_o(expire)
  );

  rst_out_map #(
    .CTL_BITS(CTL_BITS),
    .PHY_BITS(PHY_BITS)
  ) u_map (
    .state_i   (state),
    .soft_rst_o(soft_rst_o),
    .ana_rst_no(phy_ana_rst_no),
    .dig_rst_no(phy_dig_rst_no),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/ddr_rst_seq_chk.sv
module ddr_rst_seq_chk #(
  parameter int SHORT_CYC = 100,
  parameter int LONG_CYC  = 500,
  parameter int CTL_BITS  = 2,
  parameter int PHY_BITS  = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         start_i,
  input logic [CTL_BITS+PHY_BITS-1:0] soft_rst_o,
  input logic                         phy_ana_rst_no,
  input logic                         phy_dig_rst_no,
  input logic                         busy_o,
  input logic                         done_o
);
  logic [PHY_BITS-1:0] phy_bits;
  logic [CTL_BITS-1:0] ctl_bits;
  logic [31:0]         phy_gap_q, ana_gap_q;

  assign phy_bits = soft_rst_o[PHY_BITS-1:0];
  assign ctl_bits = soft_rst_o[CTL_BITS+PHY_BITS-1:PHY_BITS];

  // cycles since PHY soft reset cleared / since analog reset released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_gap_q <= '0;
      ana_gap_q <= '0;
    end else begin
      if (phy_bits != '0)                  phy_gap_q <= '0;
      else if (phy_gap_q <= 32'(LONG_CYC)) phy_gap_q <= phy_gap_q + 32'd1;
      if (!phy_ana_rst_no)                 ana_gap_q <= '0;
      else if (ana_gap_q <= 32'(LONG_CYC)) ana_gap_q <= ana_gap_q + 32'd1;
    end
  end

  AST_ALL_ASSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (&soft_rst_o) && !phy_ana_rst_no && !phy_dig_rst_no); // R2
  AST_PHY_BEFORE_CTL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|ctl_bits) |-> (phy_bits == '0)); // R3
  AST_CTL_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|ctl_bits) |-> (phy_gap_q >= 32'(LONG_CYC))); // R3
  AST_STAGE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_ana_rst_no) |-> (soft_rst_o == '0)); // R4
  AST_ANA_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_dig_rst_no) |-> phy_ana_rst_no); // R5
  AST_DIG_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_dig_rst_no) |-> (ana_gap_q >= 32'(LONG_CYC))); // R5
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o)); // R6
  AST_DONE_AFTER_DIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(phy_dig_rst_no)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o); // R7
  AST_BUSY_NO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> busy_o || done_o); // R8
  AST_DONE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_i |=> busy_o && (&soft_rst_o)); // R9
endmodule

bind ddr_rst_seq ddr_rst_seq_chk #(
  .SHORT_CYC(SHORT_CYC),
  .LONG_CYC (LONG_CYC),
  .CTL_BITS (CTL_BITS),
  .PHY_BITS (PHY_BITS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .soft_rst_o    (soft_rst_o),
  .phy_ana_rst_no(phy_ana_rst_no),
  .phy_dig_rst_no(phy_dig_rst_no),
  .busy_o        (busy_o),
  .done_o        (done_o)
);

// File: tb/ddr_rst_seq_tb.sv
module ddr_rst_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S_CYC      = 3;
  localparam int L_CYC      = 7;
  localparam int SEQ_LEN    = 2 * S_CYC + 2 * L_CYC + 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] soft_rst_o;
  logic       phy_ana_rst_no, phy_dig_rst_no, busy_o, done_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  ddr_rst_seq #(
    .SHORT_CYC(S_CYC),
    .LONG_CYC (L_CYC),
    .CTL_BITS (2),
    .PHY_BITS (2)
  ) u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .soft_rst_o    (soft_rst_o),
    .phy_ana_rst_no(phy_ana_rst_no),
    .phy_dig_rst_no(phy_dig_rst_no),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  // packed {soft[3:0], ana_n, dig_n, busy, done}
  function automatic logic [7:0] exp_at(int j);
    if (j < S_CYC)                      return 8'b1111_00_1_0;
    if (j < S_CYC + L_CYC)              return 8'b1100_00_1_0;
    if (j < 2 * S_CYC + L_CYC)          return 8'b0000_00_1_0;
    if (j < 2 * S_CYC + 2 * L_CYC)      return 8'b0000_10_1_0;
    if (j == 2 * S_CYC + 2 * L_CYC)     return 8'b0000_11_1_0;
    return 8'b0000_11_0_1;
  endfunction

  function automatic string req_at(int j);
    if (j < S_CYC)                  return "R2";
    if (j < S_CYC + L_CYC)          return "R3";
    if (j < 2 * S_CYC + L_CYC)      return "R4";
    if (j < 2 * S_CYC + 2 * L_CYC)  return "R5";
    if (j == 2 * S_CYC + 2 * L_CYC) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, logic [7:0] exp);
    logic [7:0] act;
    act = {soft_rst_o, phy_ana_rst_no, phy_dig_rst_no, busy_o, done_o};
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // start sampled at posedge 0; second start injected at posedge inj (R8 when busy)
  task automatic run_seq(int inj);
    @(negedge clk_i);
    start_i = 1'b1;
    for (int j = 0; j <= SEQ_LEN + 2; j++) begin
      @(negedge clk_i);
      if (inj > 0 && inj <= SEQ_LEN) check($sformatf("R8 inj=%0d j=%0d", inj, j), exp_at(j));
      else                           check($sformatf("%s j=%0d", req_at(j), j), exp_at(j));
      start_i = (j + 1 == inj);
    end
    start_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", 8'b1111_00_0_0);
    rst_ni = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      check("R1 idle", 8'b1111_00_0_0);
    end
    // first run from idle, then restarts from done (R9) with a swept stray start
    run_seq(0);
    for (int inj = 1; inj <= SEQ_LEN; inj++) run_seq(inj);
    run_seq(0); // R9 clean restart
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_i);
      check("R7 hold", 8'b0000_11_0_1);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule